// File: doc/BRIEF.md
# Serial Port Status and Data Register Front End

This block sits between a CPU bus and a single-buffered asynchronous serial line. It holds one transmit data byte, one receive data byte, a control byte, a line-mode byte, a baud divisor byte and an 8-bit status byte. The status byte carries four live flags: transmit-empty, receive-full, overrun and transmit-end. Software clears a flag by first reading it as 1 and then writing 0 to it. A write never sets a flag.

Writing 0 to transmit-empty, after it has been read as 1, hands the held transmit byte to the bit-level transmitter as a one-cycle start pulse. Transmit-empty and transmit-end are then set again. Bytes from the bit-level receiver are captured in the receive data register while reception is enabled. A byte that arrives while the register is still full is dropped and raises overrun. The line-mode byte is decoded into the frame settings (data bits, parity, stop bits and a power-of-four clock prescale) used by the serialiser and the baud generator.

The bus is single-cycle: a read or write strobe, a 3-bit register offset and byte-wide data. Read data is combinational from the current register state. At most one strobe is active per cycle.

Top module: `serial_flag_front`

## Requirements
- R1: After reset the status byte reads 0x84, so transmit-empty (bit 7) and transmit-end (bit 2) are set and the others are clear. The receive data, mode, baud and control registers read 0, and `tx_start` is low.
- R2: Status bits 7..3 are sticky. A status write (offset 4) clears such a bit only if the bit is 1, was read as 1 since it last rose, and the written bit is 0. A bit that has not been read is kept, and a write never sets a bit. Bit 6 is receive-full and bit 5 is overrun.
- R3: A status write stores the written bit 0 as status bit 0, and it leaves bits 2..1 clear unless R5 or R6 sets bit 2.
- R4: Each status write ANDs the written value into the record of read bits. A later write of 0 can therefore clear a read flag only if every status write since the read kept that bit at 1.
- R5: While transmit-enable (control bit 5, offset 2) is 0, status bits 7 and 2 are set after any status write.
- R6: With transmit-enable set, a status write that clears transmit-empty (bit 7) pulses `tx_start` high for exactly the next cycle, with `tx_data` equal to the last byte written at offset 3. Bits 7 and 2 then read 1.
- R7: A write of the transmit data register (offset 3) clears transmit-end (bit 2), leaves bit 7 as it was, and does not pulse `tx_start`.
- R8: With receive-enable (control bit 4) set and receive-full clear, an `rx_valid` cycle stores `rx_data` in the receive data register (offset 5) and sets receive-full.
- R9: An accepted `rx_valid` while receive-full is set leaves the receive data register unchanged and sets overrun (bit 5).
- R10: While receive-enable is 0, `rx_valid` changes neither the receive data register nor any status flag.
- R11: A read of the receive data register clears receive-full.
- R12: The mode register (offset 0) decodes as follows: bit 6 selects 7 data bits when 1 and 8 when 0; bit 5 enables parity; bit 4 selects odd parity; bit 3 selects 2 stop bits; bits 1..0 = n give `prescale` = 4^n. The mode, baud (offset 1) and control registers read back what was written, and the baud register drives `baud_div`.
- R13: A flag that rises again after an earlier read must be read again before a write of 0 can clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on status and receive data) |
| bus_addr | input | ADDR_W (3) | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tx_start | output | 1 | One-cycle strobe: send `tx_data` |
| tx_data | output | 8 | Held transmit byte |
| rx_valid | input | 1 | Receiver delivers a byte this cycle |
| rx_data | input | 8 | Received byte |
| frame_bits | output | 4 | Data bits per character (7 or 8) |
| parity_en | output | 1 | Parity enabled |
| parity_odd | output | 1 | Odd parity when 1 |
| stop_bits | output | 2 | Stop bits (1 or 2) |
| prescale | output | 7 | Baud clock prescale (1, 4, 16 or 64) |
| baud_div | output | 8 | Baud divisor register value |

## Verification
A wrong read record shows up one write later. A flag that should survive a write of 0 reads back as 0, or a read flag survives, on the very next status read. An extra or missing transmit start is visible on `tx_start` in the cycle after the status write. A receive-full or overrun error is visible on the next status read, and on the receive data register, which must keep the first byte when an overrun occurs. The bench therefore alternates reads and writes so that each rule of the read-then-clear scheme is pinned down by the status value in the next read.

// File: rtl/sff_pkg.sv
package sff_pkg;

    localparam int BYTE_W = 8;

    // status bit positions
    localparam int B_TXE  = 7;
    localparam int B_RXF  = 6;
    localparam int B_OVR  = 5;
    localparam int B_TEND = 2;
    localparam int B_WBIT = 0;

    localparam logic [BYTE_W-1:0] STAT_RESET  = 8'h84;
    localparam logic [BYTE_W-1:0] STICKY_MASK = 8'hF8;
    localparam logic [BYTE_W-1:0] TX_PAIR     = 8'h84;

    // control bit positions
    localparam int C_TX_EN = 5;
    localparam int C_RX_EN = 4;

    // mode bit positions
    localparam int M_SEVEN    = 6;
    localparam int M_PAR_EN   = 5;
    localparam int M_PAR_ODD  = 4;
    localparam int M_TWO_STOP = 3;

    typedef enum logic [2:0] {
        REG_MODE = 3'd0,
        REG_BAUD = 3'd1,
        REG_CTRL = 3'd2,
        REG_TXD  = 3'd3,
        REG_STAT = 3'd4,
        REG_RXD  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic mode_wr;
        logic baud_wr;
        logic ctrl_wr;
        logic txd_wr;
        logic stat_wr;
        logic stat_rd;
        logic rxd_rd;
    } bus_strb_t;

    typedef struct packed {
        logic [3:0] frame_bits;
        logic       parity_en;
        logic       parity_odd;
        logic [1:0] stop_bits;
        logic [6:0] prescale;
    } line_cfg_t;

    function automatic line_cfg_t decode_mode(input logic [BYTE_W-1:0] m);
        line_cfg_t c;
        c.frame_bits = m[M_SEVEN] ? 4'd7 : 4'd8;
        c.parity_en  = m[M_PAR_EN];
        c.parity_odd = m[M_PAR_ODD];
        c.stop_bits  = m[M_TWO_STOP] ? 2'd2 : 2'd1;
        c.prescale   = 7'd1 << {m[1:0], 1'b0};
        return c;
    endfunction

    // sticky bits survive unless read and written 0; bit 0 follows the write
    function automatic logic [BYTE_W-1:0] merge_status(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] seen,
        input logic [BYTE_W-1:0] wval
    );
        logic [BYTE_W-1:0] kept;
        kept = cur & (~seen | wval);
        return (kept & STICKY_MASK) | (wval & 8'h01);
    endfunction

endpackage

// File: rtl/sff_bus_decode.sv
module sff_bus_decode
    import sff_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_strb_t         strb
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e sel);
        return a == ADDR_W'(sel);
    endfunction

    always_comb begin
        strb         = '0;
        strb.mode_wr = bus_wr && hit(bus_addr, REG_MODE);
        strb.baud_wr = bus_wr && hit(bus_addr, REG_BAUD);
        strb.ctrl_wr = bus_wr && hit(bus_addr, REG_CTRL);
        strb.txd_wr  = bus_wr && hit(bus_addr, REG_TXD);
        strb.stat_wr = bus_wr && hit(bus_addr, REG_STAT);
        strb.stat_rd = bus_rd && hit(bus_addr, REG_STAT);
        strb.rxd_rd  = bus_rd && hit(bus_addr, REG_RXD);
    end

endmodule

// File: rtl/sff_cfg_regs.sv
module sff_cfg_regs
    import sff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_strb_t         strb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] baud_q,
    output logic [BYTE_W-1:0] ctrl_q,
    output line_cfg_t         cfg,
    output logic              tx_en,
    output logic              rx_en
);

    localparam int NCFG = 3;

    logic [NCFG-1:0]   we;
    logic [BYTE_W-1:0] q [NCFG];

    assign we = {strb.ctrl_wr, strb.baud_wr, strb.mode_wr};

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)        q[g] <= '0;
            else if (we[g]) q[g] <= wdata;
        end
    end

    assign mode_q = q[0];
    assign baud_q = q[1];
    assign ctrl_q = q[2];
    assign cfg    = decode_mode(q[0]);
    assign tx_en  = q[2][C_TX_EN];
    assign rx_en  = q[2][C_RX_EN];

    // R12: a written mode byte is what the register holds next cycle
    a_r12_mode_load: assert property (@(posedge clk) disable iff (rst)
        strb.mode_wr |=> (mode_q == $past(wdata)));

endmodule

// File: rtl/sff_flag_core.sv
module sff_flag_core
    import sff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_strb_t         strb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              rx_valid,
    output logic [BYTE_W-1:0] flags,
    output logic              rx_take,
    output logic              tx_start
);

    logic [BYTE_W-1:0] seen;
    logic [BYTE_W-1:0] flags_d, seen_d, wval;
    logic              fire;
    logic              rx_evt;

    assign rx_evt = rx_valid && rx_en;

    always_comb begin
        flags_d = flags;
        seen_d  = seen;
        fire    = 1'b0;
        rx_take = 1'b0;
        wval    = tx_en ? wdata : (wdata | TX_PAIR);

        if (strb.stat_rd) seen_d = seen | flags;
        if (strb.rxd_rd)  flags_d[B_RXF] = 1'b0;
        if (strb.txd_wr)  flags_d[B_TEND] = 1'b0;

        if (strb.stat_wr) begin
            flags_d = merge_status(flags, seen, wval);
            seen_d  = seen & wval;
            if (!tx_en) flags_d = flags_d | TX_PAIR;
            if (!flags_d[B_TXE]) begin
                // transmit-end drops with transmit-empty; the hand-off sets both again
                fire    = 1'b1;
                flags_d = flags_d | TX_PAIR;
            end
        end

        if (rx_evt) begin
            if (flags_d[B_RXF]) begin
                flags_d[B_OVR] = 1'b1;
            end else begin
                rx_take        = 1'b1;
                flags_d[B_RXF] = 1'b1;
                seen_d[B_RXF]  = 1'b0;
            end
        end

        // a flag that rises needs a fresh read before it can be cleared
        seen_d = seen_d & ~(flags_d & ~flags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= STAT_RESET;
            seen     <= '0;
            tx_start <= 1'b0;
        end else begin
            flags    <= flags_d;
            seen     <= seen_d;
            tx_start <= fire;
        end
    end

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strb));

    a_r2_write_never_sets: assert property (@(posedge clk) disable iff (rst)
        (strb.stat_wr && tx_en && !rx_evt) |=>
            ((flags[6:3] & ~$past(flags[6:3])) == 4'b0));

    a_r5_tx_off_pair: assert property (@(posedge clk) disable iff (rst)
        (strb.stat_wr && !tx_en) |=> (flags[B_TXE] && flags[B_TEND]));

    a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    a_r6_start_flags: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (flags[B_TXE] && flags[B_TEND]));

    a_r7_tend_drop: assert property (@(posedge clk) disable iff (rst)
        strb.txd_wr |=> (!flags[B_TEND] && !tx_start));

    a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
        (rx_evt && flags[B_RXF] && !strb.rxd_rd) |=> flags[B_OVR]);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (strb.rxd_rd && !rx_evt) |=> !flags[B_RXF]);

endmodule

// File: rtl/sff_data_regs.sv
module sff_data_regs
    import sff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_strb_t         strb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_take,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] txd_q,
    output logic [BYTE_W-1:0] rxd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_q <= '0;
            rxd_q <= '0;
        end else begin
            if (strb.txd_wr) txd_q <= wdata;
            if (rx_take)     rxd_q <= rx_byte;
        end
    end

    // R9, R10: the receive byte only changes on an accepted, non-overrun arrival
    a_r10_rx_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_take |=> $stable(rxd_q));

    a_r8_rx_load: assert property (@(posedge clk) disable iff (rst)
        rx_take |=> (rxd_q == $past(rx_byte)));

endmodule

// File: rtl/serial_flag_front.sv
module serial_flag_front
    import sff_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              tx_start,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic [3:0]        frame_bits,
    output logic              parity_en,
    output logic              parity_odd,
    output logic [1:0]        stop_bits,
    output logic [6:0]        prescale,
    output logic [7:0]        baud_div
);

    bus_strb_t         strb;
    line_cfg_t         cfg;
    logic [BYTE_W-1:0] mode_q, baud_q, ctrl_q, flags, txd_q, rxd_q;
    logic              tx_en, rx_en, rx_take;

    sff_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .strb     (strb)
    );

    sff_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .strb   (strb),
        .wdata  (bus_wdata),
        .mode_q (mode_q),
        .baud_q (baud_q),
        .ctrl_q (ctrl_q),
        .cfg    (cfg),
        .tx_en  (tx_en),
        .rx_en  (rx_en)
    );

    sff_flag_core u_flags (
        .clk      (clk),
        .rst      (rst),
        .strb     (strb),
        .wdata    (bus_wdata),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .rx_valid (rx_valid),
        .flags    (flags),
        .rx_take  (rx_take),
        .tx_start (tx_start)
    );

    sff_data_regs u_data (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .wdata   (bus_wdata),
        .rx_take (rx_take),
        .rx_byte (rx_data),
        .txd_q   (txd_q),
        .rxd_q   (rxd_q)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(REG_MODE): bus_rdata = mode_q;
            ADDR_W'(REG_BAUD): bus_rdata = baud_q;
            ADDR_W'(REG_CTRL): bus_rdata = ctrl_q;
            ADDR_W'(REG_TXD):  bus_rdata = txd_q;
            ADDR_W'(REG_STAT): bus_rdata = flags;
            ADDR_W'(REG_RXD):  bus_rdata = rxd_q;
            default:           bus_rdata = '0;
        endcase
    end

    assign tx_data    = txd_q;
    assign frame_bits = cfg.frame_bits;
    assign parity_en  = cfg.parity_en;
    assign parity_odd = cfg.parity_odd;
    assign stop_bits  = cfg.stop_bits;
    assign prescale   = cfg.prescale;
    assign baud_div   = baud_q;

endmodule

// File: tb/test_serial_flag_front.sv
module test_serial_flag_front;

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_RX = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        {K_WR, 3'd2, 8'h10, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'h84, 4'd1},   // R1
        {K_WR, 3'd4, 8'h00, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'h84, 4'd5},   // R5
        {K_WR, 3'd2, 8'h30, 8'h00, 4'd0},
        {K_RD, 3'd2, 8'h00, 8'h30, 4'd12},  // R12
        {K_WR, 3'd4, 8'h80, 8'h00, 4'd0},
        {K_WR, 3'd4, 8'h81, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'h81, 4'd3},   // R3
        {K_RX, 3'd0, 8'h5A, 8'h00, 4'd0},
        {K_WR, 3'd4, 8'h81, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'hC1, 4'd2},   // R2
        {K_WR, 3'd4, 8'hC1, 8'h00, 4'd0},
        {K_WR, 3'd4, 8'h81, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'h81, 4'd4},   // R4
        {K_RD, 3'd5, 8'h00, 8'h5A, 4'd8},   // R8
        {K_RX, 3'd0, 8'h11, 8'h00, 4'd0},
        {K_RX, 3'd0, 8'h22, 8'h00, 4'd0},
        {K_RD, 3'd5, 8'h00, 8'h11, 4'd9},   // R9
        {K_RD, 3'd4, 8'h00, 8'hA1, 4'd11},  // R11
        {K_RX, 3'd0, 8'h33, 8'h00, 4'd0},
        {K_WR, 3'd4, 8'h81, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'hC1, 4'd2},   // R2
        {K_RD, 3'd5, 8'h00, 8'h33, 4'd8},   // R8
        {K_RX, 3'd0, 8'h44, 8'h00, 4'd0},
        {K_WR, 3'd4, 8'h81, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'hC1, 4'd13},  // R13
        {K_WR, 3'd2, 8'h20, 8'h00, 4'd0},
        {K_RD, 3'd5, 8'h00, 8'h44, 4'd8},   // R8
        {K_RX, 3'd0, 8'h99, 8'h00, 4'd0},
        {K_RD, 3'd4, 8'h00, 8'h81, 4'd10},  // R10
        {K_RD, 3'd5, 8'h00, 8'h44, 4'd10},  // R10
        {K_WR, 3'd0, 8'h7B, 8'h00, 4'd0},
        {K_RD, 3'd0, 8'h00, 8'h7B, 4'd12},  // R12
        {K_WR, 3'd1, 8'h2C, 8'h00, 4'd0},
        {K_RD, 3'd1, 8'h00, 8'h2C, 4'd12}   // R12
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, rx_data = '0;
    logic [7:0] bus_rdata, tx_data, baud_div;
    logic       tx_start, parity_en, parity_odd;
    logic [3:0] frame_bits;
    logic [1:0] stop_bits;
    logic [6:0] prescale;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    serial_flag_front i_serial_flag_front (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_start(tx_start), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_data(rx_data), .frame_bits(frame_bits), .parity_en(parity_en),
        .parity_odd(parity_odd), .stop_bits(stop_bits), .prescale(prescale),
        .baud_div(baud_div)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_rx(input logic [7:0] d);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 tx_start", {7'b0, tx_start}, 8'h00);
        do_rd(3'd5, v); check("R1 rx data", v, 8'h00);
        do_rd(3'd0, v); check("R1 mode", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                K_WR: do_wr(VECS[i].addr, VECS[i].data);
                K_RX: do_rx(VECS[i].data);
                default: begin
                    do_rd(VECS[i].addr, v);
                    check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
                end
            endcase
        end

        // R12: decode of mode 0x7B and baud 0x2C
        check("R12 frame", {4'b0, frame_bits}, 8'd7);
        check("R12 parity", {6'b0, parity_en, parity_odd}, 8'h03);
        check("R12 stop", {6'b0, stop_bits}, 8'd2);
        check("R12 prescale", {1'b0, prescale}, 8'd64);
        check("R12 baud", baud_div, 8'h2C);
        do_wr(3'd0, 8'h02);
        check("R12 frame8", {4'b0, frame_bits}, 8'd8);
        check("R12 noparity", {6'b0, parity_en, parity_odd}, 8'h00);
        check("R12 stop1", {6'b0, stop_bits}, 8'd1);
        check("R12 prescale16", {1'b0, prescale}, 8'd16);

        // R7, R6: transmit hand-off (status 0x81, read record 0xC1 here)
        do_wr(3'd3, 8'hA5);
        check("R7 no start", {7'b0, tx_start}, 8'h00);
        do_wr(3'd4, 8'h01);
        check("R6 start", {7'b0, tx_start}, 8'h01);
        check("R6 byte", tx_data, 8'hA5);
        @(negedge clk);
        check("R6 single pulse", {7'b0, tx_start}, 8'h00);
        do_rd(3'd4, v); check("R6 flags set", v, 8'h85);
        do_wr(3'd3, 8'h3C);
        check("R7 no start 2", {7'b0, tx_start}, 8'h00);
        do_rd(3'd4, v); check("R7 tend cleared", v, 8'h81);
        do_wr(3'd4, 8'h85);
        check("R2 no start on keep", {7'b0, tx_start}, 8'h00);
        do_rd(3'd4, v); check("R3 bit2 not set by write", v, 8'h81);

        // R1: reset again from a busy state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_rd(3'd4, v); check("R1 status after reset", v, 8'h84);
        do_rd(3'd5, v); check("R1 rx after reset", v, 8'h00);
        do_rd(3'd1, v); check("R1 baud after reset", v, 8'h00);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule